// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block lets a host reach the management registers of an external PHY over a two-wire MDC/MDIO link using IEEE 802.3 Clause 45 frames. The host sees four 32-bit registers selected by a 2-bit offset. Every frame starts as a side effect of a host write, and the frame type depends on which register is written. Writing the address register sends an address frame. Writing the data register sends a write frame. Writing the command register with its read bit set sends a read frame.

A single status register reports whether a frame is still in flight and whether the last read turnaround was bad. The same register also holds the MDC divider. The host loads the port and device numbers once and then issues address, write and read frames against them. It polls the busy flag before each further write.

The MDC clock runs only while a frame is in progress and rests low between frames. The master changes MDIO on falling MDC edges and samples MDIO on rising edges. During the turnaround and data phases of a read frame, the master releases the line so that the PHY can drive it.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset, the status register (offset 3) reads busy (bit 0) = 0, error (bit 1) = 0 and divider (bits 15:7) = DEF_DIV (20). MDC and the MDIO output enable are both low.
- R2: The command register (offset 0) stores the device number from bits 4:0 and the port number from bits 9:5, and reads them back in the same positions. A write with bit 15 clear starts no frame.
- R3: A write to offset 1 sends an address frame, shifted out MSB first: 32 ones, start 00, op 00, 5-bit port, 5-bit device, turnaround 10, then the 16 written bits. The frame uses the port and device held in the command register.
- R4: A write to offset 2 sends a write frame with the same layout as R3, but with op 01 and the low 16 written bits as data.
- R5: A command write with bit 15 set sends a read frame with op 11 to the port and device in that same write. The output enable drops from the first turnaround bit (frame bit 46) to the end of the frame. The 16 bits sampled afterwards, MSB first, read back in bits 15:0 of offset 2, and the upper bits read zero.
- R6: The error flag (status bit 1) is set when the second turnaround bit of a read, sampled on its rising MDC edge, is 1. Every frame launch clears the flag.
- R7: Busy reads 1 from the clock edge that takes the launching write until the final falling MDC edge of the frame. MDC stays low whenever busy is 0.
- R8: While busy is set, writes to offsets 0, 1, 2 and 3 have no effect: they change no register and launch no frame.
- R9: A write to offset 3 with bit 6 set loads the divider from bits 15:7. A write with bit 6 clear leaves the divider unchanged. Each MDC half-period lasts the divider's number of system clocks.
- R10: The MDIO output changes only at falling MDC edges and holds steady while MDC is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 2 | Register offset: 0 command, 1 address, 2 data, 3 status/config |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the selected offset |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_in | input | 1 | MDIO value seen on the line |

## Verification
The bench runs all three frame kinds, with different port, device and payload values, against a bit-level PHY model. It compares each frame bit by bit together with its drive-enable pattern, which separates the op codes, the field order and the turnaround release. Reads are run twice: once with a proper zero turnaround and once with a stuck-high turnaround, and a following address frame confirms that the error flag clears. Writes sent during a busy frame, and divider loads with and without the enable bit, check that stale or unkeyed writes leave both the registers and the line untouched. Half-period measurements at two divider values tie the MDC timing to the configured count.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;
  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b11
  } mdio_op_e;

  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] IDX_LAST      = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_TA2       = IDX_W'(47);
  localparam logic [IDX_W-1:0] IDX_DATA0     = IDX_W'(48);
  localparam logic [IDX_W-1:0] IDX_PRE_TA1   = IDX_W'(45);

  typedef struct packed {
    mdio_op_e    op;
    logic [4:0]  prtad;
    logic [4:0]  devad;
    logic [15:0] payload;
  } mdio_req_t;
endpackage

// File: rtl/mdio_c45_regs.sv
module mdio_c45_regs
  import mdio_c45_pkg::*;
#(
  parameter int DIV_W   = 9,
  parameter int DEF_DIV = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr_en,
  input  logic [1:0]       host_addr,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  input  logic             busy,
  input  logic             err,
  input  logic             rd_valid,
  input  logic [15:0]      rd_word,
  output logic             launch,
  output mdio_req_t        req,
  output logic [DIV_W-1:0] div
);
  localparam int DIV_LSB = 7;

  logic [4:0]       prtad_q, prtad_d, devad_q, devad_d;
  logic [15:0]      addr_q, addr_d, rdat_q, rdat_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             wr_ok;

  assign wr_ok = host_wr_en && !busy;

  always_comb begin
    prtad_d     = prtad_q;
    devad_d     = devad_q;
    addr_d      = addr_q;
    rdat_d      = rdat_q;
    div_d       = div_q;
    launch      = 1'b0;
    req.op      = OP_ADDR;
    req.prtad   = prtad_q;
    req.devad   = devad_q;
    req.payload = host_wdata[15:0];
    if (wr_ok) begin
      case (host_addr)
        2'd0: begin
          prtad_d = host_wdata[9:5];
          devad_d = host_wdata[4:0];
          if (host_wdata[15]) begin
            launch      = 1'b1;
            req.op      = OP_READ;
            req.prtad   = host_wdata[9:5];
            req.devad   = host_wdata[4:0];
            req.payload = 16'hFFFF;
          end
        end
        2'd1: begin
          addr_d = host_wdata[15:0];
          launch = 1'b1;
          req.op = OP_ADDR;
        end
        2'd2: begin
          launch = 1'b1;
          req.op = OP_WRITE;
        end
        default: begin
          if (host_wdata[6]) div_d = host_wdata[DIV_LSB +: DIV_W];
        end
      endcase
    end
    if (rd_valid) rdat_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prtad_q <= '0;
      devad_q <= '0;
      addr_q  <= '0;
      rdat_q  <= '0;
      div_q   <= DIV_W'(DEF_DIV);
    end else begin
      prtad_q <= prtad_d;
      devad_q <= devad_d;
      addr_q  <= addr_d;
      rdat_q  <= rdat_d;
      div_q   <= div_d;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      2'd0: host_rdata[9:0] = {prtad_q, devad_q};
      2'd1: host_rdata[15:0] = addr_q;
      2'd2: host_rdata[15:0] = rdat_q;
      default: begin
        host_rdata[0] = busy;
        host_rdata[1] = err;
        host_rdata[DIV_LSB +: DIV_W] = div_q;
      end
    endcase
  end

  assign div = div_q;
endmodule

// File: rtl/mdio_c45_mdc.sv
module mdio_c45_mdc #(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, last;
  logic             mdc_q, mdc_d, wrap;

  assign last = (div == '0) ? '0 : div - DIV_W'(1);
  assign wrap = run && (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = wrap && !mdc_q;
  assign fall_tick = wrap && mdc_q;
endmodule

// File: rtl/mdio_c45_seq.sv
module mdio_c45_seq
  import mdio_c45_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  mdio_req_t   req,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_in,
  output logic        busy,
  output logic        err,
  output logic        mdio_out,
  output logic        mdio_oe,
  output logic        rd_valid,
  output logic [15:0] rd_word
);
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [15:0]           cap_q, cap_d;
  logic busy_q, busy_d, err_q, err_d, rd_q, rd_d, out_q, out_d, oe_q, oe_d;

  always_comb begin
    sh_d     = sh_q;
    idx_d    = idx_q;
    cap_d    = cap_q;
    busy_d   = busy_q;
    err_d    = err_q;
    rd_d     = rd_q;
    out_d    = out_q;
    oe_d     = oe_q;
    rd_valid = 1'b0;
    if (launch) begin
      busy_d = 1'b1;
      err_d  = 1'b0;
      sh_d   = {32'hFFFF_FFFF, 2'b00, req.op, req.prtad, req.devad, 2'b10, req.payload};
      idx_d  = '0;
      rd_d   = (req.op == OP_READ);
      out_d  = 1'b1;
      oe_d   = 1'b1;
    end else if (busy_q) begin
      if (rise_tick && rd_q) begin
        if (idx_q == IDX_TA2 && mdio_in) err_d = 1'b1;
        if (idx_q >= IDX_DATA0) cap_d = {cap_q[14:0], mdio_in};
      end
      if (fall_tick) begin
        if (idx_q == IDX_LAST) begin
          busy_d   = 1'b0;
          out_d    = 1'b0;
          oe_d     = 1'b0;
          rd_valid = rd_q;
        end else begin
          idx_d = idx_q + IDX_W'(1);
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
          out_d = sh_q[FRAME_BITS-2];
          oe_d  = !(rd_q && idx_q >= IDX_PRE_TA1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      idx_q  <= '0;
      cap_q  <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      rd_q   <= 1'b0;
      out_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      cap_q  <= cap_d;
      busy_q <= busy_d;
      err_q  <= err_d;
      rd_q   <= rd_d;
      out_q  <= out_d;
      oe_q   <= oe_d;
    end
  end

  assign busy     = busy_q;
  assign err      = err_q;
  assign mdio_out = out_q;
  assign mdio_oe  = oe_q;
  assign rd_word  = cap_q;
endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
  import mdio_c45_pkg::*;
#(
  parameter int DIV_W   = 9,
  parameter int DEF_DIV = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr_en,
  input  logic [1:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             busy, err, launch, rd_valid, rise_tick, fall_tick;
  logic [15:0]      rd_word;
  logic [DIV_W-1:0] div;
  mdio_req_t        req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  mdio_c45_regs #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy), .err(err),
    .rd_valid(rd_valid), .rd_word(rd_word), .launch(launch), .req(req), .div(div)
  );

  mdio_c45_mdc #(.DIV_W(DIV_W)) u_mdc (
    .clk(clk), .rst_n(rst_sync_n), .run(busy), .div(div),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_c45_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .launch(launch), .req(req),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_in(mdio_in),
    .busy(busy), .err(err), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .rd_valid(rd_valid), .rd_word(rd_word)
  );
endmodule

// File: rtl/mdio_c45_master_chk.sv
module mdio_c45_master_chk #(
  parameter int DIV_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             err,
  input logic             mdc,
  input logic             mdio_out,
  input logic             mdio_oe,
  input logic [DIV_W-1:0] div
);
  a_r7_mdc_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  a_r10_out_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$stable(mdio_out)) |-> $fell(mdc));

  a_r1_drive_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);

  a_r8_div_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(div));

  a_r6_err_clear_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !err);
endmodule

bind mdio_c45_master mdio_c45_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .busy(busy), .err(err), .mdc(mdc),
  .mdio_out(mdio_out), .mdio_oe(mdio_oe), .div(div)
);

// File: tb/mdio_c45_master_test.sv
module mdio_c45_master_test;
  typedef struct {
    logic [63:0] bits;
    logic [63:0] drv;
    string       tag;
  } frame_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int n_cmp = 0, n_bad = 0, frames = 0, rcnt = 0, hi_bad = 0;
  bit done = 1'b0;
  frame_t exp_q[$];
  logic [63:0] got_b, got_o;
  logic held;
  logic        phy_rd = 1'b0, phy_ta_bad = 1'b0;
  logic [15:0] phy_data = '0;

  always #2 clk = !clk;

  mdio_c45_master uut (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  function automatic frame_t mk(input logic [1:0] op, input logic [4:0] p,
                                input logic [4:0] d, input logic [15:0] v, input string tag);
    frame_t f;
    f.bits = {32'hFFFF_FFFF, 2'b00, op, p, d, 2'b10, v};
    f.drv  = (op == 2'b11) ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
    f.tag  = tag;
    return f;
  endfunction

  // monitor: assemble each 64-bit frame on rising MDC and score it
  initial begin
    forever begin
      @(posedge mdc);
      got_b[63-rcnt] = mdio_out;
      got_o[63-rcnt] = mdio_oe;
      held = mdio_out;
      if (rcnt == 63) begin
        frame_t e;
        rcnt = 0;
        frames++;
        if (exp_q.size() == 0) begin
          check("R8 unexpected frame", got_b, 64'h0);
        end else begin
          e = exp_q.pop_front();
          n_cmp++;
          if (got_o !== e.drv || (got_b & e.drv) !== (e.bits & e.drv)) begin
            n_bad++;
            $display("FAIL %s actual %h/%h expected %h/%h", e.tag, got_b, got_o, e.bits, e.drv);
          end
        end
        check("R10 MDIO steady while MDC high", 64'(hi_bad), 64'h0);
        hi_bad = 0;
      end else begin
        rcnt++;
      end
    end
  end

  always @(negedge clk) if (mdc && mdio_out !== held) hi_bad++;

  // PHY model: drives the line after falling MDC for the next bit
  always @(negedge mdc) begin
    if (phy_rd && rcnt == 47)      mdio_in = phy_ta_bad;
    else if (phy_rd && rcnt >= 48) mdio_in = phy_data[63-rcnt];
    else                           mdio_in = 1'b1;
  end

  task automatic hw(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr_en = 1'b1;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic hr(input logic [1:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    do begin
      @(negedge clk);
      hr(2'd3, s);
    end while (s[0]);
  endtask

  task automatic half_period(output int n);
    n = 0;
    @(posedge mdc);
    while (mdc) begin
      @(posedge clk);
      #1;
      n++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual running expected done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    hr(2'd3, r);
    check("R1 status after reset", 64'(r), 64'h0000_0A00);
    check("R1 mdc/oe after reset", {62'b0, mdc, mdio_oe}, 64'h0);

    // R2 command register fields, no launch
    hw(2'd0, 32'h0000_007E);
    hr(2'd0, r);
    check("R2 command readback", 64'(r), 64'h7E);
    hr(2'd3, r);
    check("R2 no launch without bit 15", 64'(r[0]), 64'h0);

    // R3 address frame, R7 busy, R9 default half-period
    exp_q.push_back(mk(2'b00, 5'h03, 5'h1E, 16'hC0DE, "R3 address frame"));
    hw(2'd1, 32'h0000_C0DE);
    hr(2'd3, r);
    check("R7 busy right after launch", 64'(r[0]), 64'h1);
    half_period(n);
    check("R9 default half-period", 64'(n), 64'd20);
    wait_idle();
    check("R7 mdc low when idle", 64'(mdc), 64'h0);

    // R9 divider load key
    hw(2'd3, 32'h0000_0108);
    hr(2'd3, r);
    check("R9 write without bit 6 ignored", 64'(r), 64'h0000_0A00);
    hw(2'd3, 32'h0000_0148);
    hr(2'd3, r);
    check("R9 divider loaded", 64'(r), 64'h0000_0100);

    // R4 write frame; R8 writes while busy
    exp_q.push_back(mk(2'b01, 5'h03, 5'h1E, 16'h5A5A, "R4 write frame"));
    hw(2'd2, 32'h0000_5A5A);
    half_period(n);
    check("R9 half-period at divider 2", 64'(n), 64'd2);
    hw(2'd2, 32'h0000_1111);
    hw(2'd0, 32'h0000_83FF);
    hw(2'd1, 32'h0000_2222);
    hw(2'd3, 32'h0000_03C8);
    wait_idle();
    hr(2'd0, r);
    check("R8 command kept while busy", 64'(r), 64'h7E);
    hr(2'd1, r);
    check("R8 address kept while busy", 64'(r), 64'hC0DE);
    hr(2'd3, r);
    check("R8 divider kept while busy", 64'(r), 64'h0000_0100);

    // R5 read frame with good turnaround
    phy_rd = 1'b1; phy_ta_bad = 1'b0; phy_data = 16'hA5C3;
    exp_q.push_back(mk(2'b11, 5'h07, 5'h01, 16'h0000, "R5 read frame"));
    hw(2'd0, 32'h0000_80E1);
    wait_idle();
    hr(2'd2, r);
    check("R5 read data", 64'(r), 64'h0000_A5C3);
    hr(2'd0, r);
    check("R5 command holds read target", 64'(r), 64'hE1);
    hr(2'd3, r);
    check("R6 no error on good turnaround", 64'(r[1]), 64'h0);

    // R6 read with stuck-high turnaround
    phy_ta_bad = 1'b1; phy_data = 16'h0F0F;
    exp_q.push_back(mk(2'b11, 5'h07, 5'h01, 16'h0000, "R5 second read frame"));
    hw(2'd0, 32'h0000_80E1);
    wait_idle();
    hr(2'd3, r);
    check("R6 error on bad turnaround", 64'(r[1]), 64'h1);
    hr(2'd2, r);
    check("R5 second read data", 64'(r), 64'h0000_0F0F);

    // R6 error cleared by the next launch; R3 second pattern
    phy_rd = 1'b0; phy_ta_bad = 1'b0;
    exp_q.push_back(mk(2'b00, 5'h07, 5'h01, 16'h0001, "R3 address frame 2"));
    hw(2'd1, 32'h0000_0001);
    hr(2'd3, r);
    check("R6 error cleared at launch", 64'(r[1]), 64'h0);
    wait_idle();

    repeat (200) @(negedge clk);
    check("R8 frame count", 64'(frames), 64'd5);
    check("R8 scoreboard drained", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule